// File: doc/BRIEF.md
# MDIO-to-32-bit register bridge

This block lets a management station that only speaks 16-bit MDIO register transactions reach a 32-bit, byte-addressed register space inside the chip. The MDIO frame parser sits in front of it. It hands the bridge single-cycle read and write strobes together with the 5-bit PHY address, the 5-bit register number and 16-bit write data. The two top bits of the PHY address choose what the access means. It can load a page register, reach an internal register, or pass straight through to a real PHY on the same MDIO bus.

The internal byte address is 19 bits wide. The page register supplies the upper ten bits, so each page is a 512-byte window. The three low PHY-address bits supply the next three, and the register number supplies the five below those. The register number's lowest bit selects the 16-bit half of a 32-bit word. Software writes the upper half first, and that half is held in the bridge. The lower-half write then commits the whole word to the internal bus in a single cycle. For reads it goes the other way round. A lower-half read fetches the whole word and keeps its upper half for the upper-half read that follows, so both halves come from the same fetch.

A small array of 32-bit registers on a 4-byte stride stands in for the real register file.

Top module: `mdio_reg_bridge`

## Requirements
- R1: Mode is PHY-address bits 4:3. Value 3 = page select, 2 = register access, 0 = bypass. Value 1 is ignored: no bus access, no forwarded strobe and no read response.
- R2: A page-mode write loads write-data bits 9:0 into the page register, which then appears as bus address bits 18:9. Write-data bits 15:10 are dropped. The page register resets to 0. A page-mode read returns a response with data 0, so the page value cannot be read back.
- R3: In register mode the bus address is the page register on bits 18:9, PHY-address bits 2:0 on bits 8:6, register-number bits 4:1 on bits 5:2, and zero on bits 1:0.
- R4: A register-mode write with register-number bit 0 = 1 (upper half, byte offset +2) causes no bus write. Its data is held for the next lower-half write.
- R5: A register-mode write with register-number bit 0 = 0 (lower half) asserts bus_we in the same cycle as the strobe, for exactly that cycle. bus_wdata is {held upper half, write data}.
- R6: A register-mode read with register-number bit 0 = 0 asserts bus_re in the same cycle. mdio_rvalid is high on the following cycle, and mdio_rdata then holds word bits 15:0.
- R7: A register-mode read with register-number bit 0 = 1 returns bits 31:16 captured by the most recent lower-half read, even if the word was written in between.
- R8: In bypass mode, fwd_wr and fwd_rd follow the MDIO strobes in the same cycle, and fwd_phy, fwd_regnum and fwd_wdata carry the MDIO fields. No bus access and no mdio_rvalid result.
- R9: The stand-in array holds DEPTH_WORDS words at byte addresses below DEPTH_WORDS*4. Reads at or above that limit return 0, and writes there are dropped without aliasing.
- R10: After reset mdio_rvalid and mdio_rdata are 0 and both half-word holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_wr | input | 1 | Decoded MDIO write strobe, one cycle |
| mdio_rd | input | 1 | Decoded MDIO read strobe, one cycle |
| mdio_phy | input | 5 | MDIO PHY address (mode in bits 4:3) |
| mdio_regnum | input | 5 | MDIO register number |
| mdio_wdata | input | 16 | MDIO write data |
| mdio_rdata | output | 16 | Read data, valid with mdio_rvalid |
| mdio_rvalid | output | 1 | Read response, one cycle after the strobe |
| bus_we | output | 1 | Internal bus write enable |
| bus_re | output | 1 | Internal bus read enable |
| bus_addr | output | 19 | Internal byte address |
| bus_wdata | output | 32 | Internal bus write data |
| fwd_wr | output | 1 | Bypass write strobe toward a real PHY |
| fwd_rd | output | 1 | Bypass read strobe toward a real PHY |
| fwd_phy | output | 5 | Bypass PHY address |
| fwd_regnum | output | 5 | Bypass register number |
| fwd_wdata | output | 16 | Bypass write data |

## Verification
On every cycle the assertions check the following:
- At most one access type is decoded per strobe.
- A page write shows up on the bus address on the next cycle.
- Every register or page read is answered one cycle later.
- A lower-half read captures the fetched upper half.
- A bypass strobe never produces a response.

Only the bench scenarios can show the rest:
- Full 32-bit words land at the arithmetically expected addresses across whole page windows.
- Pages outside the array neither store nor alias.
- An upper-half read stays coherent with its earlier lower-half fetch when the word is rewritten in between.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int PHY_W  = 5;
  localparam int REGN_W = 5;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PAGE_W = 10;
  localparam int ADDR_W = PAGE_W + 3 + REGN_W + 1;
  localparam int WADR_W = ADDR_W - 2;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_REGACC = 2'd2,
    MODE_PAGE   = 2'd3
  } acc_mode_e;

  // Word address: page, PHY low bits, register number without the half-select bit
  function automatic logic [WADR_W-1:0] word_addr(input logic [PAGE_W-1:0] page,
                                                  input logic [2:0] phy_lo,
                                                  input logic [REGN_W-2:0] reg_hi);
    return {page, phy_lo, reg_hi};
  endfunction

  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic              half_sel,
  output logic              pg_wr,
  output logic              pg_rd,
  output logic              hi_wr,
  output logic              lo_wr,
  output logic              hi_rd,
  output logic              lo_rd,
  output logic              byp_wr,
  output logic              byp_rd
);
  acc_mode_e mode;
  logic      is_reg;

  assign mode   = acc_mode_e'(phy[PHY_W-1:PHY_W-2]);
  assign is_reg = (mode == MODE_REGACC);

  always_comb begin
    pg_wr  = wr && (mode == MODE_PAGE);
    pg_rd  = rd && (mode == MODE_PAGE);
    hi_wr  = wr && is_reg && half_sel;
    lo_wr  = wr && is_reg && !half_sel;
    hi_rd  = rd && is_reg && half_sel;
    lo_rd  = rd && is_reg && !half_sel;
    byp_wr = wr && (mode == MODE_BYPASS);
    byp_rd = rd && (mode == MODE_BYPASS);
  end

  // R1
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_wr, pg_rd, hi_wr, lo_wr, hi_rd, lo_rd, byp_wr, byp_rd}));
endmodule

// File: rtl/mrb_halves.sv
module mrb_halves
  import mrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_wr,
  input  logic              pg_rd,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic              hi_rd,
  input  logic              lo_rd,
  input  logic [2:0]        phy_lo,
  input  logic [REGN_W-2:0] reg_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] rdata,
  output logic              rvalid
);
  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] hold_wr_q;
  logic [HALF_W-1:0] hold_rd_q;
  logic [HALF_W-1:0] rdata_q;
  logic              rvalid_q;

  assign bus_we    = lo_wr;
  assign bus_re    = lo_rd;
  assign bus_addr  = {word_addr(page_q, phy_lo, reg_hi), 2'b00};
  assign bus_wdata = join_halves(hold_wr_q, wdata);
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      hold_wr_q <= '0;
      hold_rd_q <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      if (pg_wr) page_q <= wdata[PAGE_W-1:0];
      if (hi_wr) hold_wr_q <= wdata;
      if (lo_rd) hold_rd_q <= bus_rdata[WORD_W-1:HALF_W];
      rvalid_q <= pg_rd || lo_rd || hi_rd;
      if (lo_rd)      rdata_q <= bus_rdata[HALF_W-1:0];
      else if (hi_rd) rdata_q <= hold_rd_q;
      else if (pg_rd) rdata_q <= '0;
    end
  end

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |=> bus_addr[ADDR_W-1:ADDR_W-PAGE_W] == $past(wdata[PAGE_W-1:0]));
  // R6
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd || hi_rd || pg_rd) |=> rvalid);
  // R6
  lo_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> rdata == $past(bus_rdata[HALF_W-1:0]));
  // R7
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> hold_rd_q == $past(bus_rdata[WORD_W-1:HALF_W]));
  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> bus_wdata[WORD_W-1:HALF_W] == $past(wdata));
endmodule

// File: rtl/mrb_store.sv
module mrb_store
  import mrb_pkg::*;
#(
  parameter int DEPTH_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WADR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);
  localparam logic [WADR_W-1:0] LIMIT = WADR_W'(DEPTH_WORDS);

  logic [WORD_W-1:0] mem [DEPTH_WORDS];
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = waddr < LIMIT;
  assign idx      = waddr[IDX_W-1:0];
  assign rdata    = in_range ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH_WORDS; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[idx] <= wdata;
    end
  end

  // R9
  oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> rdata == '0);
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mrb_pkg::*;
#(
  parameter int DEPTH_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_wr,
  input  logic              mdio_rd,
  input  logic [PHY_W-1:0]  mdio_phy,
  input  logic [REGN_W-1:0] mdio_regnum,
  input  logic [HALF_W-1:0] mdio_wdata,
  output logic [HALF_W-1:0] mdio_rdata,
  output logic              mdio_rvalid,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              fwd_wr,
  output logic              fwd_rd,
  output logic [PHY_W-1:0]  fwd_phy,
  output logic [REGN_W-1:0] fwd_regnum,
  output logic [HALF_W-1:0] fwd_wdata
);
  logic pg_wr, pg_rd, hi_wr, lo_wr, hi_rd, lo_rd;
  logic [WORD_W-1:0] bus_rdata;

  mrb_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr(mdio_wr), .rd(mdio_rd), .phy(mdio_phy),
    .half_sel(mdio_regnum[0]),
    .pg_wr(pg_wr), .pg_rd(pg_rd), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .hi_rd(hi_rd), .lo_rd(lo_rd), .byp_wr(fwd_wr), .byp_rd(fwd_rd)
  );

  mrb_halves u_half (
    .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_rd(pg_rd), .hi_wr(hi_wr),
    .lo_wr(lo_wr), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .phy_lo(mdio_phy[2:0]), .reg_hi(mdio_regnum[REGN_W-1:1]),
    .wdata(mdio_wdata), .bus_rdata(bus_rdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rdata(mdio_rdata), .rvalid(mdio_rvalid)
  );

  mrb_store #(.DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .waddr(bus_addr[ADDR_W-1:2]),
    .wdata(bus_wdata), .rdata(bus_rdata)
  );

  assign fwd_phy    = mdio_phy;
  assign fwd_regnum = mdio_regnum;
  assign fwd_wdata  = mdio_wdata;

  // R8
  bypass_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr || fwd_rd) |=> !mdio_rvalid);
  // R8
  bypass_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr || fwd_rd) |-> !(bus_we || bus_re));
endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;
  logic clk = 0, rst_n = 0;
  logic mdio_wr = 0, mdio_rd = 0;
  logic [4:0] mdio_phy = 0, mdio_regnum = 0;
  logic [15:0] mdio_wdata = 0;
  logic [15:0] mdio_rdata;
  logic mdio_rvalid, bus_we, bus_re, fwd_wr, fwd_rd;
  logic [18:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [4:0] fwd_phy, fwd_regnum;
  logic [15:0] fwd_wdata;

  int total = 0, bad = 0;
  bit done = 0;

  logic c_we, c_re, c_fwr, c_frd, c_rv;
  logic [18:0] c_addr;
  logic [31:0] c_wdata;
  logic [15:0] c_rdata;

  mdio_reg_bridge uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int idx, input int salt);
    return (32'(idx) * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ 32'(salt);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
    @(negedge clk);
    mdio_phy = phy; mdio_regnum = rn; mdio_wdata = d; mdio_wr = 1;
    #1;
    c_we = bus_we; c_addr = bus_addr; c_wdata = bus_wdata; c_fwr = fwd_wr;
    @(negedge clk);
    mdio_wr = 0;
    c_rv = mdio_rvalid;
  endtask

  task automatic do_rd(input logic [4:0] phy, input logic [4:0] rn);
    @(negedge clk);
    mdio_phy = phy; mdio_regnum = rn; mdio_rd = 1;
    #1;
    c_re = bus_re; c_frd = fwd_rd; c_addr = bus_addr;
    @(negedge clk);
    mdio_rd = 0;
    c_rv = mdio_rvalid; c_rdata = mdio_rdata;
  endtask

  // word w (0..127) inside current page
  function automatic logic [4:0] phy_of(input int w);
    return {2'b10, 3'(w >> 4)};
  endfunction
  function automatic logic [4:0] rn_of(input int w, input bit hi);
    return {4'(w), hi};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] word;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 rvalid", 32'(mdio_rvalid), 0);
    chk("R10 rdata", 32'(mdio_rdata), 0);
    #1;
    chk("R10 hold", bus_wdata[31:16], 0);

    // R2 / R3 page is 0 after reset, address composition
    do_wr(5'b10011, 5'b01100, 16'h1234);
    chk("R2 reset page", 32'(c_addr[18:9]), 0);
    chk("R3 addr", 32'(c_addr), {10'd0, 3'b011, 4'b0110, 2'b00});

    // sweep pages 0 and 1 with full-word writes
    for (int p = 0; p < 2; p++) begin
      do_wr(5'b11000, 5'd0, 16'hFC00 | 16'(p));
      for (int w = 0; w < 128; w++) begin
        word = pat(p * 128 + w, 0);
        do_wr(phy_of(w), rn_of(w, 1), word[31:16]);
        chk("R4 upper write no bus", 32'(c_we), 0);
        do_wr(phy_of(w), rn_of(w, 0), word[15:0]);
        chk("R5 lower write we", 32'(c_we), 1);
        chk("R5 wdata", c_wdata, word);
        chk("R3 addr sweep", 32'(c_addr), {10'(p), 7'(w), 2'b00});
      end
    end

    // read sweep
    for (int p = 0; p < 2; p++) begin
      do_wr(5'b11000, 5'd0, 16'(p));
      for (int w = 0; w < 128; w++) begin
        word = pat(p * 128 + w, 0);
        do_rd(phy_of(w), rn_of(w, 0));
        chk("R6 bus_re", 32'(c_re), 1);
        chk("R6 rvalid", 32'(c_rv), 1);
        chk("R6 low half", 32'(c_rdata), 32'(word[15:0]));
        do_rd(phy_of(w), rn_of(w, 1));
        chk("R7 upper rvalid", 32'(c_rv), 1);
        chk("R7 upper half", 32'(c_rdata), 32'(word[31:16]));
      end
    end

    // R9 out of range page 2: dropped, reads 0, no alias onto page 0
    do_wr(5'b11000, 5'd0, 16'd2);
    do_wr(phy_of(5), rn_of(5, 1), 16'hDEAD);
    do_wr(phy_of(5), rn_of(5, 0), 16'hBEEF);
    chk("R9 oob addr", 32'(c_addr), {10'd2, 7'd5, 2'b00});
    do_rd(phy_of(5), rn_of(5, 0));
    chk("R9 oob low", 32'(c_rdata), 0);
    do_rd(phy_of(5), rn_of(5, 1));
    chk("R9 oob high", 32'(c_rdata), 0);
    do_wr(5'b11000, 5'd0, 16'd0);
    word = pat(5, 0);
    do_rd(phy_of(5), rn_of(5, 0));
    chk("R9 no alias", 32'(c_rdata), 32'(word[15:0]));

    // R7 coherence: rewrite between low and high reads
    word = pat(3, 0);
    do_rd(phy_of(3), rn_of(3, 0));
    do_wr(phy_of(3), rn_of(3, 1), 16'h7777);
    do_wr(phy_of(3), rn_of(3, 0), 16'h8888);
    do_rd(phy_of(3), rn_of(3, 1));
    chk("R7 coherent upper", 32'(c_rdata), 32'(word[31:16]));
    do_rd(phy_of(3), rn_of(3, 0));
    do_rd(phy_of(3), rn_of(3, 1));
    chk("R7 new upper", 32'(c_rdata), 32'h7777);

    // R8 bypass
    @(negedge clk);
    mdio_phy = 5'b00101; mdio_regnum = 5'd9; mdio_wdata = 16'hA5C3; mdio_wr = 1;
    #1;
    chk("R8 fwd_wr", 32'(fwd_wr), 1);
    chk("R8 fwd fields", {fwd_phy, fwd_regnum, fwd_wdata}, {5'b00101, 5'd9, 16'hA5C3});
    chk("R8 no bus_we", 32'(bus_we), 0);
    @(negedge clk);
    mdio_wr = 0;
    chk("R8 no rvalid after wr", 32'(mdio_rvalid), 0);
    do_rd(5'b00111, 5'd2);
    chk("R8 fwd_rd", 32'(c_frd), 1);
    chk("R8 no bus_re", 32'(c_re), 0);
    chk("R8 no rvalid after rd", 32'(c_rv), 0);

    // R1 mode 1 ignored
    do_wr(5'b01000, 5'd0, 16'h4242);
    chk("R1 rsvd no bus_we", 32'(c_we), 0);
    chk("R1 rsvd no fwd", 32'(c_fwr), 0);
    do_rd(5'b01000, 5'd0);
    chk("R1 rsvd no rvalid", 32'(c_rv), 0);
    chk("R1 rsvd no bus_re", 32'(c_re), 0);
    word = pat(0, 0);
    do_rd(phy_of(0), rn_of(0, 0));
    chk("R1 rsvd no change", 32'(c_rdata), 32'(word[15:0]));

    // R2 page read answers 0
    do_wr(5'b11000, 5'd0, 16'd1);
    do_rd(5'b11000, 5'd0);
    chk("R2 page read rvalid", 32'(c_rv), 1);
    chk("R2 page read data", 32'(c_rdata), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule